// File: doc/BRIEF.md
# Sprite Pixel Serializer, Dual Output

This block turns one 32-bit graphics ROM word, holding a full 8-pixel sprite line at 4 bits per pixel, into two 4-bit pixel streams called A and B. Each stream has a flag that marks the pixel as opaque. A word is captured on a rising clock edge while the load strobe is high. On each falling edge that follows, the block presents the next pair of pixels, so one line is used up in four steps.

Two control inputs shape each line. The flip input mirrors the line by reversing the pixel order. The swap input exchanges the pixel routed to A with the pixel routed to B. Both inputs are captured together with the word and hold for the whole line. When the line is used up and no new word has been loaded, both streams go transparent. A load on the rising edge that follows the fourth pair chains the next line with no gap.

Top module: `sprite_pair_serializer`

## Requirements
- R1: When load is high at a rising edge of clk, rom_word is captured, and the first pixel pair of that word appears on the falling edge that follows.
- R2: Pixel n of a word occupies bits [4n+3:4n]. With flip and swap both low, step k (k = 0..3) shows pixel 2k on pix_a and pixel 2k+1 on pix_b.
- R3: With flip high, step k shows pixel 7-2k on pix_a and pixel 6-2k on pix_b, so the line comes out mirrored.
- R4: With swap high, the pixels that would go to pix_a and pix_b are exchanged, in both flip settings.
- R5: opaque_a is high exactly when pix_a is nonzero, and opaque_b is high exactly when pix_b is nonzero.
- R6: After four steps with no new load, pix_a and pix_b are 0 and both opaque flags are low, until the next load.
- R7: A load on the rising edge after the fourth pair puts step 0 of the new word on the next falling edge, with no idle step between the lines.
- R8: hflip and swap_ab are sampled only at load time. Changing them in the middle of a line has no effect on that line.
- R9: rst is a synchronous, active-high reset. While it is held, all outputs are 0 and no line is in progress.
- R10: A load in the middle of a line drops the rest of the old line and starts the new word at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock. Words are captured on the rising edge and pixels are presented on the falling edge. |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for rom_word and the line controls |
| rom_word | input | 32 | One line of 8 pixels at 4 bits each |
| hflip | input | 1 | Mirror the line |
| swap_ab | input | 1 | Exchange the A and B pixels |
| pix_a | output | 4 | Colour index of stream A |
| opaque_a | output | 1 | Stream A pixel is non-transparent |
| pix_b | output | 4 | Colour index of stream B |
| opaque_b | output | 1 | Stream B pixel is non-transparent |

## Verification
Some properties are checked on every cycle: each opacity flag matches its index, the outputs are zero under reset, the outputs go dark once four steps pass without a load, and step 0 of a plain line carries the two lowest pixels. The full pixel order under every flip and swap combination is shown only by the bench scenarios. The same holds for ignoring control changes in mid-line, the gapless chaining of lines and the restart on a mid-line load. The bench compares each falling-edge output against a model built from the requirements.

// File: rtl/sprite_pair_serializer.sv
module sprite_pair_serializer #(
  parameter int PIX_W = 4,
  parameter int PIX_N = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [PIX_W*PIX_N-1:0] rom_word,
  input  logic                   hflip,
  input  logic                   swap_ab,
  output logic [PIX_W-1:0]       pix_a,
  output logic                   opaque_a,
  output logic [PIX_W-1:0]       pix_b,
  output logic                   opaque_b
);
  localparam int WW    = PIX_W * PIX_N;
  localparam int STEPS = PIX_N / 2;
  localparam int SW    = $clog2(STEPS);
  localparam int IW    = SW + 1;

  logic [WW-1:0]    word_q;
  logic [SW-1:0]    step_q;
  logic             live_q, flip_q, swap_q;
  logic [PIX_W-1:0] pix [PIX_N];

  // capture on the rising edge, advance one pair per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      step_q <= '0;
      live_q <= 1'b0;
      flip_q <= 1'b0;
      swap_q <= 1'b0;
    end else if (load) begin
      word_q <= rom_word;
      step_q <= '0;
      live_q <= 1'b1;
      flip_q <= hflip;
      swap_q <= swap_ab;
    end else if (live_q) begin
      if (step_q == SW'(STEPS - 1)) live_q <= 1'b0;
      step_q <= step_q + 1'b1;
    end
  end

  for (genvar g = 0; g < PIX_N; g++) begin : g_pix
    assign pix[g] = word_q[g*PIX_W +: PIX_W];
  end

  logic [SW-1:0]    pair;
  logic [IW-1:0]    first_i, second_i;
  logic [PIX_W-1:0] nxt_a, nxt_b;

  assign pair     = flip_q ? (SW'(STEPS - 1) - step_q) : step_q;
  assign first_i  = flip_q ? {pair, 1'b1} : {pair, 1'b0};
  assign second_i = flip_q ? {pair, 1'b0} : {pair, 1'b1};
  assign nxt_a    = swap_q ? pix[second_i] : pix[first_i];
  assign nxt_b    = swap_q ? pix[first_i]  : pix[second_i];

  // present the pair on the falling edge
  always_ff @(negedge clk) begin
    if (rst || !live_q) begin
      pix_a    <= '0;
      pix_b    <= '0;
      opaque_a <= 1'b0;
      opaque_b <= 1'b0;
    end else begin
      pix_a    <= nxt_a;
      pix_b    <= nxt_b;
      opaque_a <= |nxt_a;
      opaque_b <= |nxt_b;
    end
  end
endmodule

// File: rtl/sprite_pair_serializer_chk.sv
module sprite_pair_serializer_chk #(
  parameter int PIX_W = 4,
  parameter int PIX_N = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   load,
  input logic [PIX_W*PIX_N-1:0] rom_word,
  input logic                   hflip,
  input logic                   swap_ab,
  input logic [PIX_W-1:0]       pix_a,
  input logic                   opaque_a,
  input logic [PIX_W-1:0]       pix_b,
  input logic                   opaque_b
);
  localparam int STEPS = PIX_N / 2;
  localparam int CW    = $clog2(STEPS) + 1;

  logic [CW-1:0]          since_load;
  logic [PIX_W*PIX_N-1:0] word_c;
  logic                   plain_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_load <= CW'(2*STEPS - 1);
      word_c     <= '0;
      plain_c    <= 1'b0;
    end else if (load) begin
      since_load <= '0;
      word_c     <= rom_word;
      plain_c    <= !hflip && !swap_ab;
    end else if (since_load != CW'(2*STEPS - 1)) begin
      since_load <= since_load + 1'b1;
    end
  end

  // R5
  opacity_a_chk: assert property (@(posedge clk) disable iff (rst)
    opaque_a == (pix_a != '0));

  // R5
  opacity_b_chk: assert property (@(posedge clk) disable iff (rst)
    opaque_b == (pix_b != '0));

  // R6
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (since_load >= CW'(STEPS)) |-> (pix_a == '0 && pix_b == '0 && !opaque_a && !opaque_b));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    ($past(rst) && rst) |-> (pix_a == '0 && pix_b == '0 && !opaque_a && !opaque_b));

  // R2
  first_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (since_load == '0 && plain_c) |->
      (pix_a == word_c[PIX_W-1:0] && pix_b == word_c[2*PIX_W-1:PIX_W]));
endmodule

bind sprite_pair_serializer sprite_pair_serializer_chk #(.PIX_W(PIX_W), .PIX_N(PIX_N)) u_chk (
  .clk(clk), .rst(rst), .load(load), .rom_word(rom_word), .hflip(hflip), .swap_ab(swap_ab),
  .pix_a(pix_a), .opaque_a(opaque_a), .pix_b(pix_b), .opaque_b(opaque_b)
);

// File: tb/sprite_pair_serializer_tb.sv
`timescale 1ns/1ps
module sprite_pair_serializer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] rom_word = '0;
  logic        hflip = 1'b0;
  logic        swap_ab = 1'b0;
  logic [3:0]  pix_a, pix_b;
  logic        opaque_a, opaque_b;

  int checks = 0;
  int errors = 0;

  // bench model of the line in progress
  logic [31:0] m_word = '0;
  int          m_step = 0;
  bit          m_live = 0;
  bit          m_flip = 0;
  bit          m_swap = 0;

  sprite_pair_serializer u_dut (
    .clk(clk), .rst(rst), .load(load), .rom_word(rom_word), .hflip(hflip),
    .swap_ab(swap_ab), .pix_a(pix_a), .opaque_a(opaque_a), .pix_b(pix_b), .opaque_b(opaque_b)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] px(logic [31:0] w, int n);
    return w[4*n +: 4];
  endfunction

  function automatic logic [3:0] exp_pix(bit lane_b);
    int ia, ib;
    if (!m_live) return 4'd0;
    ia = m_flip ? 7 - 2*m_step : 2*m_step;
    ib = m_flip ? 6 - 2*m_step : 2*m_step + 1;
    if (m_swap) lane_b = !lane_b;
    return lane_b ? px(m_word, ib) : px(m_word, ia);
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_live = 0; m_step = 0;
    end else if (load) begin
      m_word = rom_word; m_step = 0; m_live = 1; m_flip = hflip; m_swap = swap_ab;
    end else if (m_live) begin
      if (m_step == 3) m_live = 0;
      m_step = m_step + 1;
    end
  endtask

  task automatic check_out(string tag);
    logic [3:0] ea, eb;
    ea = exp_pix(0);
    eb = exp_pix(1);
    checks++;
    if (pix_a !== ea || pix_b !== eb) begin
      errors++;
      $display("FAIL %s pixels: got A=%h B=%h expected A=%h B=%h", tag, pix_a, pix_b, ea, eb);
    end
    checks++;
    if (opaque_a !== (ea != 0) || opaque_b !== (eb != 0)) begin
      errors++;
      $display("FAIL R5 opacity: got %b%b expected %b%b", opaque_a, opaque_b, ea != 0, eb != 0);
    end
  endtask

  // one clock: rising edge captures inputs, falling edge presents, then sample
  task automatic cycle(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    check_out(tag);
  endtask

  function automatic string auto_tag();
    if (!m_live) return "R6";
    if (m_flip) return "R3";
    if (m_swap) return "R4";
    return "R2";
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9 reset
    repeat (3) cycle("R9");
    rst = 1'b0;

    // R1/R2 plain line
    load = 1; rom_word = 32'h7654_3210; hflip = 0; swap_ab = 0;
    cycle("R1");
    load = 0;
    repeat (3) cycle("R2");
    repeat (2) cycle("R6");

    // R3 flip, R8 controls changed mid-line
    load = 1; rom_word = 32'h89AB_CDEF; hflip = 1; swap_ab = 0;
    cycle("R3");
    load = 0; hflip = 0; swap_ab = 1;
    repeat (3) cycle("R8");

    // R7 back-to-back, R4 swap with flip
    load = 1; rom_word = 32'h0F0E_0D0C; hflip = 1; swap_ab = 1;
    cycle("R7");
    load = 0;
    repeat (3) cycle("R4");
    load = 1; rom_word = 32'h1020_3040; hflip = 0; swap_ab = 1;
    cycle("R7");
    load = 0;
    cycle("R4");

    // R10 mid-line reload
    load = 1; rom_word = 32'hA0B0_C0D0; hflip = 0; swap_ab = 0;
    cycle("R10");
    load = 0;
    repeat (4) cycle("R6");

    // R9 reset mid-line
    load = 1; rom_word = 32'h1111_2222;
    cycle("R1");
    load = 0; rst = 1;
    cycle("R9");
    cycle("R9");
    rst = 0;

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      load     = ($urandom % 4) == 0;
      rom_word = $urandom;
      if (($urandom % 5) == 0) rom_word[15:0] = 16'h0;
      hflip    = $urandom % 2;
      swap_ab  = $urandom % 2;
      rst      = ($urandom % 200) == 0;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      #1;
      check_out(rst ? "R9" : auto_tag());
    end
    rst = 0; load = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule